// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block moves a processor subsystem into a low-power mode and back again. It controls three supply domains: core logic (index 0), floating-point unit (index 1) and on-chip RAM (index 2). Software first latches a target for each domain, a wakeup-source mask and a reset-hold length with a single arm strobe. The sequence then starts when the processor signals wait-for-interrupt. The controller gates clocks, isolates outputs, and then either requests retention voltage or opens the power switch, domain by domain. It waits for the regulator to report a settled supply and then holds the subsystem asleep.

An enabled interrupt brings the domains back up in the reverse order. Supply is restored first. Isolation and clocks are restored only after the regulator settles. Reset of any domain that was switched off is released a programmable number of cycles after its clock restarts. The regulator is outside the block and appears only as request outputs and one settled-acknowledge input. Status outputs report the current mode, a busy flag, the wakeup source and a settle-timeout error.

Top module: `pwr_mode_seq`

## Requirements
- R1: An arm strobe is accepted only while the controller is idle and awake. It latches per-domain targets coded 0 = full, 1 = retention, 2 or 3 = off, the wake mask and the hold length, and it sets `armed`. While a sequence runs or the block is asleep the strobe has no effect.
- R2: A sleep sequence starts only when `wfi` is high in a cycle where `armed` is already set. An unarmed `wfi` leaves every output unchanged and `busy` low.
- R3: On entry, domains whose target is not full first drop their clock enable. One cycle later their isolation rises. One cycle after that the power step is taken. No two steps share a cycle.
- R4: In the power step, a retention target raises that domain's `dom_vret`, and an off target clears its `dom_pwr_en`. A full-target domain keeps clock on, isolation off and power on throughout.
- R5: After the power step, and again after supply is restored on wake, the controller waits for `vreq_ack`. If the acknowledge is missing for TMO_CYC cycles, it sets `settle_err` and proceeds.
- R6: While asleep, `irq` wakes the block only if mask bit 0 is set, and `fiq` only if mask bit 1 is set. Wake restores power and clears retention first. After settling it removes isolation, and one cycle later it re-enables the clocks. `wake_src` records {fiq hit, irq hit}.
- R7: `dom_rst` of an off domain rises together with the power-off step. It falls `hold_cyc` cycles after the clock-restore step, with a minimum of one cycle.
- R8: An interrupt while the block is armed but before `wfi` causes no transition and leaves `armed` set. `arm_clr` clears `armed`.
- R9: Completing a wake clears `armed` and returns `mode` to 0 (active). While asleep, `mode` reads 1 for standby (all full), 2 for deep standby (some retention, nothing off in core or RAM), 3 for dormant (core off, RAM kept) and 4 for shutdown (RAM off).
- R10: `settle_err` stays set through the wake and is cleared only by the next accepted arm strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_set | input | 1 | Latch configuration and arm |
| arm_clr | input | 1 | Disarm |
| tgt_core | input | 2 | Core domain target |
| tgt_fpu | input | 2 | FPU domain target |
| tgt_ram | input | 2 | RAM domain target |
| wake_en | input | 2 | Wake mask: bit 0 irq, bit 1 fiq |
| hold_cyc | input | HOLD_W | Reset hold cycles after clock restore |
| wfi | input | 1 | Processor wait-for-interrupt indication |
| irq | input | 1 | Interrupt request |
| fiq | input | 1 | Fast interrupt request |
| vreq_ack | input | 1 | Regulator reports supply settled |
| dom_clk_en | output | 3 | Per-domain clock enable |
| dom_iso | output | 3 | Per-domain isolation enable |
| dom_pwr_en | output | 3 | Per-domain power switch enable |
| dom_vret | output | 3 | Per-domain retention voltage request |
| dom_rst | output | 3 | Per-domain reset |
| armed | output | 1 | Arm state |
| busy | output | 1 | Sequence in progress |
| mode | output | 3 | Current mode code |
| wake_src | output | 2 | Source of last wake {fiq, irq} |
| settle_err | output | 1 | Regulator acknowledge timed out |

## Verification
The hardest situation to reach is a settle that never completes. The bench reaches it by holding `vreq_ack` low across both the entry and the wake settle windows. It then confirms that the error survives the wake and is cleared only by the next arm. A second stimulus raises the acknowledge partway through the window, to tell a late acknowledge apart from a timeout. Ignored arm strobes and masked interrupts are applied while the block is asleep, and their lack of effect is read back through `mode`, `armed` and the domain outputs.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int NDOM = 3;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CLKOFF, PH_ISO, PH_PWROFF, PH_SETTLE_DN, PH_SLEEP,
    PH_PWRON, PH_SETTLE_UP, PH_ISOOFF, PH_CLKON, PH_RSTREL
  } phase_e;

  typedef enum logic [2:0] {
    MD_ACTIVE = 3'd0, MD_STANDBY = 3'd1, MD_DEEP = 3'd2,
    MD_DORMANT = 3'd3, MD_SHUTDOWN = 3'd4
  } mode_e;

  localparam logic [1:0] TG_FULL = 2'd0;
  localparam logic [1:0] TG_RET  = 2'd1;

  function automatic mode_e classify(input logic [1:0] c, input logic [1:0] f,
                                     input logic [1:0] r);
    if (r[1])                                    return MD_SHUTDOWN;
    else if (c[1])                               return MD_DORMANT;
    else if (c != TG_FULL || f != TG_FULL || r != TG_FULL) return MD_DEEP;
    else                                         return MD_STANDBY;
  endfunction
endpackage

// File: rtl/pms_count.sv
module pms_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pms_domain.sv
module pms_domain
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_e     ph,
  input  logic [1:0] tgt,
  input  logic       hold_done,
  output logic       clk_en,
  output logic       iso,
  output logic       pwr_en,
  output logic       vret,
  output logic       dom_rst
);
  logic aff, goes_off, goes_ret;
  assign aff      = (tgt != TG_FULL);
  assign goes_off = tgt[1];
  assign goes_ret = (tgt == TG_RET);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en  <= 1'b1;
      iso     <= 1'b0;
      pwr_en  <= 1'b1;
      vret    <= 1'b0;
      dom_rst <= 1'b0;
    end else begin
      case (ph)
        PH_CLKOFF: if (aff) clk_en <= 1'b0;
        PH_ISO:    if (aff) iso <= 1'b1;
        PH_PWROFF: begin
          if (goes_off) begin
            pwr_en  <= 1'b0;
            dom_rst <= 1'b1;
          end
          if (goes_ret) vret <= 1'b1;
        end
        PH_PWRON: begin
          pwr_en <= 1'b1;
          vret   <= 1'b0;
        end
        PH_ISOOFF: iso <= 1'b0;
        PH_CLKON:  clk_en <= 1'b1;
        PH_RSTREL: if (hold_done) dom_rst <= 1'b0;
        default: ;
      endcase
    end
  end

  // R3: isolation rises only once the clock is already gated
  a_r3_iso_after_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(iso) |-> !clk_en);
  // R3: the switch opens only behind isolation
  a_r3_switch_after_iso: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> iso);
  // R4: an unpowered domain is isolated and clock-gated
  a_r4_off_is_fenced: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> (iso && !clk_en));
  // R7: an unpowered domain sits in reset
  a_r7_off_in_reset: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> dom_rst);
  // R6: clocks return only on full supply with isolation gone
  a_r6_clock_after_power: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> (pwr_en && !vret && !iso));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TMO_CYC = 1000,
  parameter int HOLD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic [1:0]        tgt_core,
  input  logic [1:0]        tgt_fpu,
  input  logic [1:0]        tgt_ram,
  input  logic [1:0]        wake_en,
  input  logic [HOLD_W-1:0] hold_cyc,
  input  logic              wfi,
  input  logic              irq,
  input  logic              fiq,
  input  logic              vreq_ack,
  output logic [2:0]        dom_clk_en,
  output logic [2:0]        dom_iso,
  output logic [2:0]        dom_pwr_en,
  output logic [2:0]        dom_vret,
  output logic [2:0]        dom_rst,
  output logic              armed,
  output logic              busy,
  output logic [2:0]        mode,
  output logic [1:0]        wake_src,
  output logic              settle_err
);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  phase_e             ph, ph_nxt;
  logic [1:0]         tgt_q [NDOM];
  logic [1:0]         wen_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         wake_hit;
  logic               settle_to, hold_done;

  assign wake_hit  = {fiq & wen_q[1], irq & wen_q[0]};
  assign settle_to = (cnt == TMO_LAST);
  assign hold_done = ((32'(cnt) + 32'd1) >= 32'(hold_q));
  assign busy      = (ph != PH_IDLE) && (ph != PH_SLEEP);

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:      if (armed && wfi) ph_nxt = PH_CLKOFF;
      PH_CLKOFF:    ph_nxt = PH_ISO;
      PH_ISO:       ph_nxt = PH_PWROFF;
      PH_PWROFF:    ph_nxt = PH_SETTLE_DN;
      PH_SETTLE_DN: if (vreq_ack || settle_to) ph_nxt = PH_SLEEP;
      PH_SLEEP:     if (|wake_hit) ph_nxt = PH_PWRON;
      PH_PWRON:     ph_nxt = PH_SETTLE_UP;
      PH_SETTLE_UP: if (vreq_ack || settle_to) ph_nxt = PH_ISOOFF;
      PH_ISOOFF:    ph_nxt = PH_CLKON;
      PH_CLKON:     ph_nxt = PH_RSTREL;
      PH_RSTREL:    if (hold_done) ph_nxt = PH_IDLE;
      default:      ph_nxt = PH_IDLE;
    endcase
  end

  pms_count #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (ph_nxt != ph),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      armed      <= 1'b0;
      wen_q      <= '0;
      hold_q     <= '0;
      settle_err <= 1'b0;
      mode       <= MD_ACTIVE;
      wake_src   <= '0;
      for (int d = 0; d < NDOM; d++) tgt_q[d] <= TG_FULL;
    end else begin
      ph <= ph_nxt;
      if (arm_set && ph == PH_IDLE) begin
        armed      <= 1'b1;
        tgt_q[0]   <= tgt_core;
        tgt_q[1]   <= tgt_fpu;
        tgt_q[2]   <= tgt_ram;
        wen_q      <= wake_en;
        hold_q     <= hold_cyc;
        settle_err <= 1'b0;
      end else if (arm_clr) begin
        armed <= 1'b0;
      end
      if ((ph == PH_SETTLE_DN || ph == PH_SETTLE_UP) && !vreq_ack && settle_to)
        settle_err <= 1'b1;
      if (ph == PH_SETTLE_DN && ph_nxt == PH_SLEEP)
        mode <= classify(tgt_q[0], tgt_q[1], tgt_q[2]);
      if (ph == PH_SLEEP && |wake_hit)
        wake_src <= wake_hit;
      if (ph == PH_RSTREL && hold_done) begin
        armed <= 1'b0;
        mode  <= MD_ACTIVE;
      end
    end
  end

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    pms_domain u_dom (
      .clk       (clk),
      .rst       (rst),
      .ph        (ph),
      .tgt       (tgt_q[g]),
      .hold_done (hold_done),
      .clk_en    (dom_clk_en[g]),
      .iso       (dom_iso[g]),
      .pwr_en    (dom_pwr_en[g]),
      .vret      (dom_vret[g]),
      .dom_rst   (dom_rst[g])
    );
  end

  // R2: without arm the controller never leaves idle
  a_r2_idle_without_arm: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !armed) |=> (ph == PH_IDLE));
  // R6: masked or absent interrupts keep the block asleep
  a_r6_sleep_holds: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SLEEP && !(irq && wen_q[0]) && !(fiq && wen_q[1])) |=> (ph == PH_SLEEP));
  // R9: a finished wake leaves the block disarmed and active
  a_r9_disarm_after_wake: assert property (@(posedge clk) disable iff (rst)
    ($past(ph) == PH_RSTREL && ph == PH_IDLE) |-> (!armed && mode == MD_ACTIVE));
  // R5: sleep is reached only on an acknowledge or with the error raised
  a_r5_settle_gate: assert property (@(posedge clk) disable iff (rst)
    ($past(ph) == PH_SETTLE_DN && ph == PH_SLEEP) |-> ($past(vreq_ack) || settle_err));
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int TMO = 16;

  logic       clk = 1'b0, rst = 1'b1;
  logic       arm_set = 0, arm_clr = 0, wfi = 0, irq = 0, fiq = 0, vreq_ack = 1;
  logic [1:0] tgt_core = 0, tgt_fpu = 0, tgt_ram = 0, wake_en = 0;
  logic [7:0] hold_cyc = 0;
  logic [2:0] dom_clk_en, dom_iso, dom_pwr_en, dom_vret, dom_rst, mode;
  logic       armed, busy, settle_err;
  logic [1:0] wake_src;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.CNT_W(16), .TMO_CYC(TMO), .HOLD_W(8)) u0 (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr),
    .tgt_core(tgt_core), .tgt_fpu(tgt_fpu), .tgt_ram(tgt_ram),
    .wake_en(wake_en), .hold_cyc(hold_cyc), .wfi(wfi), .irq(irq), .fiq(fiq),
    .vreq_ack(vreq_ack), .dom_clk_en(dom_clk_en), .dom_iso(dom_iso),
    .dom_pwr_en(dom_pwr_en), .dom_vret(dom_vret), .dom_rst(dom_rst),
    .armed(armed), .busy(busy), .mode(mode), .wake_src(wake_src),
    .settle_err(settle_err)
  );

  // behavioural reference: step number, timers and expected pins
  int st, cnt, m_armed, m_err, m_mode, m_src, wen, hold, a_old;
  int tg [3];
  bit [2:0] m_clk, m_iso, m_pwr, m_vret, m_rst;

  function automatic int mode_of(int c, int f, int r);
    if (r >= 2) return 4;
    if (c >= 2) return 3;
    if (c != 0 || f != 0 || r != 0) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st = 0; cnt = 0; m_armed = 0; m_err = 0; m_mode = 0; m_src = 0;
      wen = 0; hold = 0; m_clk = 3'b111; m_pwr = 3'b111; m_iso = 0;
      m_vret = 0; m_rst = 0;
      for (int d = 0; d < 3; d++) tg[d] = 0;
    end else begin
      a_old = m_armed;
      if (arm_set && st == 0) begin
        m_armed = 1; tg[0] = tgt_core; tg[1] = tgt_fpu; tg[2] = tgt_ram;
        wen = wake_en; hold = hold_cyc; m_err = 0;
      end else if (arm_clr) m_armed = 0;
      case (st)
        0: if (a_old != 0 && wfi) st = 1;
        1: begin for (int d = 0; d < 3; d++) if (tg[d] != 0) m_clk[d] = 0; st = 2; end
        2: begin for (int d = 0; d < 3; d++) if (tg[d] != 0) m_iso[d] = 1; st = 3; end
        3: begin
          for (int d = 0; d < 3; d++) begin
            if (tg[d] >= 2) begin m_pwr[d] = 0; m_rst[d] = 1; end
            if (tg[d] == 1) m_vret[d] = 1;
          end
          st = 4; cnt = 0;
        end
        4, 7: begin
          if (vreq_ack || cnt == TMO - 1) begin
            if (!vreq_ack) m_err = 1;
            if (st == 4) begin m_mode = mode_of(tg[0], tg[1], tg[2]); st = 5; end
            else st = 8;
          end else cnt++;
        end
        5: if ((irq && wen[0]) || (fiq && wen[1])) begin
          m_src = ((fiq && wen[1]) ? 2 : 0) + ((irq && wen[0]) ? 1 : 0);
          st = 6;
        end
        6: begin m_pwr = 3'b111; m_vret = 0; st = 7; cnt = 0; end
        8: begin m_iso = 0; st = 9; end
        9: begin m_clk = 3'b111; st = 10; cnt = 0; end
        10: if (cnt + 1 >= hold) begin
          m_rst = 0; m_armed = 0; m_mode = 0; st = 0;
        end else cnt++;
        default: st = 0;
      endcase
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R3", "dom_clk_en", dom_clk_en, m_clk);
      check("R3", "dom_iso", dom_iso, m_iso);
      check("R4", "dom_pwr_en", dom_pwr_en, m_pwr);
      check("R4", "dom_vret", dom_vret, m_vret);
      check("R7", "dom_rst", dom_rst, m_rst);
      check("R8", "armed", armed, m_armed);
      check("R2", "busy", busy, (st != 0 && st != 5) ? 1 : 0);
      check("R9", "mode", mode, m_mode);
      check("R6", "wake_src", wake_src, m_src);
      check("R5", "settle_err", settle_err, m_err);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
      finish_run();
    end
  end

  task automatic arm(int c, int f, int r, int we, int h);
    tgt_core = 2'(c); tgt_fpu = 2'(f); tgt_ram = 2'(r);
    wake_en = 2'(we); hold_cyc = 8'(h);
    arm_set = 1; @(negedge clk); arm_set = 0;
  endtask

  task automatic pulse_wfi(); wfi = 1; @(negedge clk); wfi = 0; endtask
  task automatic pulse_irq(); irq = 1; @(negedge clk); irq = 0; endtask
  task automatic pulse_fiq(); fiq = 1; @(negedge clk); fiq = 0; endtask

  task automatic wait_sleep();
    for (int i = 0; i < 200 && !(mode != 0 && !busy); i++) @(negedge clk);
  endtask
  task automatic wait_awake();
    for (int i = 0; i < 200 && !(mode == 0 && !busy); i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2", "reset pwr", dom_pwr_en, 3'b111);
    check("R2", "reset clk", dom_clk_en, 3'b111);
    check("R2", "reset armed", armed, 0);

    // R2: unarmed wfi does nothing
    pulse_wfi(); repeat (3) @(negedge clk);
    check("R2", "unarmed busy", busy, 0);
    check("R2", "unarmed mode", mode, 0);

    // deep standby: core ret, fpu off, ram ret, irq only
    arm(1, 2, 1, 1, 2);
    pulse_irq(); @(negedge clk);
    check("R8", "early irq armed", armed, 1);
    check("R8", "early irq mode", mode, 0);
    pulse_wfi(); wait_sleep();
    check("R9", "deep mode", mode, 2);
    check("R1", "deep vret", dom_vret, 3'b101);
    check("R1", "deep pwr", dom_pwr_en, 3'b101);
    check("R7", "deep rst", dom_rst, 3'b010);
    fiq = 1; repeat (3) @(negedge clk); fiq = 0;
    check("R6", "masked fiq", mode, 2);
    pulse_irq(); wait_awake();
    check("R9", "wake disarms", armed, 0);
    check("R6", "src irq", wake_src, 1);
    check("R7", "rst released", dom_rst, 0);
    pulse_wfi(); repeat (4) @(negedge clk);
    check("R9", "plain wfi busy", busy, 0);
    check("R9", "plain wfi mode", mode, 0);

    // shutdown with a late acknowledge, fiq only
    arm(2, 2, 2, 2, 5);
    vreq_ack = 0; pulse_wfi(); repeat (8) @(negedge clk);
    check("R5", "waiting for ack", busy, 1);
    vreq_ack = 1; wait_sleep();
    check("R9", "shutdown mode", mode, 4);
    check("R5", "no error", settle_err, 0);
    arm(0, 0, 0, 1, 0);
    pulse_irq(); repeat (2) @(negedge clk);
    check("R1", "arm ignored asleep", mode, 4);
    check("R1", "pwr kept", dom_pwr_en, 0);
    pulse_fiq(); wait_awake();
    check("R6", "src fiq", wake_src, 2);

    // dormant, both sources together, zero hold
    arm(2, 2, 1, 3, 0);
    pulse_wfi(); wait_sleep();
    check("R9", "dormant mode", mode, 3);
    irq = 1; fiq = 1; @(negedge clk); irq = 0; fiq = 0;
    wait_awake();
    check("R6", "src both", wake_src, 3);

    // standby: all full, nothing moves
    arm(0, 0, 0, 1, 1);
    pulse_wfi(); wait_sleep();
    check("R9", "standby mode", mode, 1);
    check("R4", "standby clk", dom_clk_en, 3'b111);
    pulse_irq(); wait_awake();

    // timeouts on both settles
    arm(1, 0, 0, 1, 1);
    vreq_ack = 0; pulse_wfi(); wait_sleep();
    check("R5", "timeout err", settle_err, 1);
    pulse_irq(); wait_awake();
    check("R10", "err after wake", settle_err, 1);
    vreq_ack = 1;
    arm(0, 0, 0, 1, 1);
    check("R10", "err cleared by arm", settle_err, 0);
    arm_clr = 1; @(negedge clk); arm_clr = 0;
    check("R8", "clr disarms", armed, 0);
    pulse_wfi(); repeat (4) @(negedge clk);
    check("R8", "no entry after clr", busy, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule